// File: doc/BRIEF.md
# Configurable GPIO Port with Bus-Strobe Alternate Function

This block is an 8-bit general-purpose I/O port driven through a small register interface. Software writes an output latch, a per-bit direction register and a per-bit function register. A read of the data register returns a mix: the pad value for bits set as inputs, and the latch value for bits set as outputs. Bits 0 and 1 are always outputs. When their function bits are set, they carry the read and write strobes of the external bus controller. A strobe reaches the pin only while an external-area access is in progress; at all other times the pin rests at the inactive level, which is high.

Each bit has a pull-up enable output. Its reset value, like the reset value of the latch bits 2 to 6, comes from a strap input that is sampled while reset is asserted. Bit 7 is pulled up whenever it is an input. Bits 2 and 6 are also pulled up while the bus-acknowledge input is low and their function bit is set. Registers are selected by a 2-bit address: 0 is the data latch, 1 is direction, 2 is function and 3 is unused.

Top module: `gpio_port`

## Requirements
- R1: While `rst` is high at a clock edge, the direction and function registers clear to 0 and latch bits 0, 1 and 7 become 1. After reset, `pin_oe` is 8'h03 and `pin_out[1:0]` is 2'b11.
- R2: While `rst` is high, latch bits 2 to 6 take the value of `strap_pu`, so the latch is 8'hFF with the strap high and 8'h83 with the strap low.
- R3: `pin_oe[1:0]` is always 2'b11. For bits 2 to 7, `pin_oe[i]` equals direction bit i, where 1 means output.
- R4: Direction bits 0 and 1 and function bits 3 and 7 are not implemented. They read back as 0 and writes to them have no effect, so the readback masks are 8'hFC for direction and 8'h77 for function.
- R5: A write with `wr_en` high updates the register selected by `reg_addr` at the next rising clock edge, and not before. A write to address 3 changes nothing.
- R6: A read at address 0 returns, for each bit, the latch bit if the bit is an output (bits 0 and 1, or direction bit 1) and `pin_in` otherwise. Addresses 1 and 2 return the masked registers, and address 3 returns 0.
- R7: With function bit 0 set, `pin_out[0]` equals `rd_strobe_n` while `ext_access` is high, and is 1 while `ext_access` is low.
- R8: With function bit 1 set, `pin_out[1]` follows the same rule using `wr_strobe_n`.
- R9: A pin whose function bit is clear, or which is a bit from 2 to 7, drives its latch value on `pin_out`.
- R10: `pull_en[1:0]` is always 0. For bits 2 to 6, when the bit is an input, `pull_en` equals the strap value sampled at reset. `pull_en[7]` is 1 whenever bit 7 is an input.
- R11: `pull_en[2]` and `pull_en[6]` are also 1 when `bus_ack` is 0 and the matching function bit is 1, whatever the strap and direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| strap_pu | input | 1 | Pull-up strap, sampled while reset is high |
| wr_en | input | 1 | Register write enable |
| reg_addr | input | 2 | Register select: 0 data, 1 direction, 2 function |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Combinational read data |
| pin_in | input | 8 | Pad input values |
| pin_out | output | 8 | Pad output values |
| pin_oe | output | 8 | Pad output enables |
| pull_en | output | 8 | Pad pull-up enables |
| ext_access | input | 1 | External-area access in progress |
| rd_strobe_n | input | 1 | Read strobe from the bus controller, active low |
| wr_strobe_n | input | 1 | Write strobe from the bus controller, active low |
| bus_ack | input | 1 | Bus acknowledge, active low for the pull-up rule |

## Verification
A function-register write can arrive in the same cycle in which an external read access is already driving its strobe low. The bench provokes this by holding the latch bit at 1 with the strobe active, then raising the write for function bit 0. It samples `pin_out[0]` once before the clock edge and expects the latch value, then samples it after the edge and expects the strobe value. It applies the same treatment to a function write that meets a low `bus_ack`: the bit 2 pull-up must stay off before the edge and come on after it.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

    localparam int PORT_W   = 8;
    localparam int ADDR_W   = 2;
    localparam int RD_BIT   = 0;
    localparam int WR_BIT   = 1;

    // implemented-bit masks and reset constants
    localparam logic [PORT_W-1:0] DIR_MASK    = 8'hFC;
    localparam logic [PORT_W-1:0] FUNC_MASK   = 8'h77;
    localparam logic [PORT_W-1:0] FIXED_OUT   = 8'h03;
    localparam logic [PORT_W-1:0] STRAP_BITS  = 8'h7C;
    localparam logic [PORT_W-1:0] LATCH_ONES  = 8'h83;
    localparam logic [PORT_W-1:0] ALWAYS_PU   = 8'h80;
    localparam logic [PORT_W-1:0] ACK_PU_BITS = 8'h44;

    typedef enum logic [ADDR_W-1:0] {
        SEL_DATA = 2'd0,
        SEL_DIR  = 2'd1,
        SEL_FUNC = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic [PORT_W-1:0] latch;
        logic [PORT_W-1:0] dir;
        logic [PORT_W-1:0] func;
    } port_regs_t;

    typedef struct packed {
        logic       active;
        logic       rd_n;
        logic       wr_n;
    } bus_strobe_t;

    function automatic logic [PORT_W-1:0] latch_reset(input logic strap);
        return LATCH_ONES | (strap ? STRAP_BITS : '0);
    endfunction

    function automatic logic [PORT_W-1:0] out_mask(input logic [PORT_W-1:0] dir);
        return dir | FIXED_OUT;
    endfunction

endpackage

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
    import gpio_port_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                strap_pu,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic [PORT_W-1:0]   wr_data,
    output port_regs_t          regs,
    output logic                pu_strap
);

    reg_sel_e sel;
    assign sel = reg_sel_e'(reg_addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            regs.latch <= latch_reset(strap_pu);
            regs.dir   <= '0;
            regs.func  <= '0;
            pu_strap   <= strap_pu;
        end else if (wr_en) begin
            case (sel)
                SEL_DATA: regs.latch <= wr_data;
                SEL_DIR:  regs.dir   <= wr_data & DIR_MASK;
                SEL_FUNC: regs.func  <= wr_data & FUNC_MASK;
                default:  ;
            endcase
        end
    end

    // R1: control registers clear and fixed latch bits set under reset
    a_r1_reset_values: assert property (@(posedge clk)
        rst |=> (regs.dir == '0 && regs.func == '0 && regs.latch[1:0] == 2'b11 && regs.latch[7]));

    // R2: strap copied into latch bits 2..6
    a_r2_strap_latch: assert property (@(posedge clk)
        rst |=> (regs.latch[6:2] == {5{$past(strap_pu)}}));

    // R5: data write lands on the next edge
    a_r5_data_write: assert property (@(posedge clk) disable iff (rst)
        (wr_en && reg_addr == SEL_DATA) |=> (regs.latch == $past(wr_data)));

    // R5: unused address leaves all registers untouched
    a_r5_none_write: assert property (@(posedge clk) disable iff (rst)
        (wr_en && reg_addr == SEL_NONE) |=> $stable(regs));

    // R4: unimplemented bits never hold a 1
    a_r4_unimpl_zero: assert property (@(posedge clk) disable iff (rst)
        ((regs.dir & ~DIR_MASK) == '0 && (regs.func & ~FUNC_MASK) == '0));

endmodule

// File: rtl/gpio_port_outmux.sv
module gpio_port_outmux
    import gpio_port_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  port_regs_t          regs,
    input  bus_strobe_t         bus,
    output logic [PORT_W-1:0]   pin_out,
    output logic [PORT_W-1:0]   pin_oe
);

    assign pin_oe = out_mask(regs.dir);

    for (genvar i = 0; i < PORT_W; i++) begin : g_bit
        if (i == RD_BIT || i == WR_BIT) begin : g_strobe
            logic strobe_n;
            assign strobe_n   = (i == RD_BIT) ? bus.rd_n : bus.wr_n;
            assign pin_out[i] = regs.func[i] ? (bus.active ? strobe_n : 1'b1)
                                             : regs.latch[i];
        end else begin : g_plain
            assign pin_out[i] = regs.latch[i];
        end
    end

    // R3: strobe-capable bits always drive
    a_r3_low_oe: assert property (@(posedge clk) disable iff (rst)
        pin_oe[1:0] == 2'b11);

    // R7: idle read strobe pin rests high
    a_r7_rd_idle: assert property (@(posedge clk) disable iff (rst)
        (regs.func[RD_BIT] && !bus.active) |-> pin_out[RD_BIT]);

    // R7: active access passes the read strobe
    a_r7_rd_pass: assert property (@(posedge clk) disable iff (rst)
        (regs.func[RD_BIT] && bus.active) |-> (pin_out[RD_BIT] == bus.rd_n));

    // R8: write strobe pin follows the same rule
    a_r8_wr_pass: assert property (@(posedge clk) disable iff (rst)
        regs.func[WR_BIT] |-> (pin_out[WR_BIT] == (bus.active ? bus.wr_n : 1'b1)));

    // R9: non-strobe pins show the latch
    a_r9_latch_out: assert property (@(posedge clk) disable iff (rst)
        pin_out[PORT_W-1:2] == regs.latch[PORT_W-1:2]);

endmodule

// File: rtl/gpio_port_pullctl.sv
module gpio_port_pullctl
    import gpio_port_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  port_regs_t          regs,
    input  logic                pu_strap,
    input  logic                bus_ack,
    output logic [PORT_W-1:0]   pull_en
);

    logic [PORT_W-1:0] is_input;
    logic [PORT_W-1:0] strap_pu_bits;
    logic [PORT_W-1:0] ack_pu_bits;

    assign is_input      = ~out_mask(regs.dir);
    assign strap_pu_bits = pu_strap ? STRAP_BITS : '0;
    assign ack_pu_bits   = bus_ack ? '0 : (regs.func & ACK_PU_BITS);
    assign pull_en       = (is_input & (strap_pu_bits | ALWAYS_PU)) | ack_pu_bits;

    // R10: output-only bits never pulled up
    a_r10_low_nopull: assert property (@(posedge clk) disable iff (rst)
        pull_en[1:0] == 2'b00);

    // R10: bit 7 pulled up as input
    a_r10_top_pull: assert property (@(posedge clk) disable iff (rst)
        !regs.dir[7] |-> pull_en[7]);

    // R11: acknowledge-low pull-up on bits 2 and 6
    a_r11_ack_pull: assert property (@(posedge clk) disable iff (rst)
        (!bus_ack && regs.func[2] && regs.func[6]) |-> (pull_en[2] && pull_en[6]));

endmodule

// File: rtl/gpio_port.sv
module gpio_port
    import gpio_port_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                strap_pu,
    input  logic                wr_en,
    input  logic [1:0]          reg_addr,
    input  logic [7:0]          wr_data,
    output logic [7:0]          rd_data,
    input  logic [7:0]          pin_in,
    output logic [7:0]          pin_out,
    output logic [7:0]          pin_oe,
    output logic [7:0]          pull_en,
    input  logic                ext_access,
    input  logic                rd_strobe_n,
    input  logic                wr_strobe_n,
    input  logic                bus_ack
);

    port_regs_t  regs;
    logic        pu_strap;
    bus_strobe_t bus;

    assign bus = '{active: ext_access, rd_n: rd_strobe_n, wr_n: wr_strobe_n};

    gpio_port_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .strap_pu (strap_pu),
        .wr_en    (wr_en),
        .reg_addr (reg_addr),
        .wr_data  (wr_data),
        .regs     (regs),
        .pu_strap (pu_strap)
    );

    gpio_port_outmux u_outmux (
        .clk     (clk),
        .rst     (rst),
        .regs    (regs),
        .bus     (bus),
        .pin_out (pin_out),
        .pin_oe  (pin_oe)
    );

    gpio_port_pullctl u_pullctl (
        .clk      (clk),
        .rst      (rst),
        .regs     (regs),
        .pu_strap (pu_strap),
        .bus_ack  (bus_ack),
        .pull_en  (pull_en)
    );

    logic [PORT_W-1:0] drive_mask;
    assign drive_mask = out_mask(regs.dir);

    always_comb begin
        case (reg_sel_e'(reg_addr))
            SEL_DATA: rd_data = (regs.latch & drive_mask) | (pin_in & ~drive_mask);
            SEL_DIR:  rd_data = regs.dir & DIR_MASK;
            SEL_FUNC: rd_data = regs.func & FUNC_MASK;
            default:  rd_data = '0;
        endcase
    end

    // R6: data read of an output bit returns the latch
    a_r6_read_out: assert property (@(posedge clk) disable iff (rst)
        (reg_addr == 2'd0) |-> ((rd_data & pin_oe) == (regs.latch & pin_oe)));

    // R6: data read of an input bit returns the pad
    a_r6_read_in: assert property (@(posedge clk) disable iff (rst)
        (reg_addr == 2'd0) |-> ((rd_data & ~pin_oe) == (pin_in & ~pin_oe)));

endmodule

// File: tb/gpio_port_tb.sv
`timescale 1ns/1ps
module gpio_port_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       strap_pu = 1'b1;
    logic       wr_en = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic [7:0] pin_in = 8'h00;
    logic [7:0] pin_out;
    logic [7:0] pin_oe;
    logic [7:0] pull_en;
    logic       ext_access = 1'b0;
    logic       rd_strobe_n = 1'b1;
    logic       wr_strobe_n = 1'b1;
    logic       bus_ack = 1'b1;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    gpio_port u_dut (
        .clk(clk), .rst(rst), .strap_pu(strap_pu), .wr_en(wr_en),
        .reg_addr(reg_addr), .wr_data(wr_data), .rd_data(rd_data),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .pull_en(pull_en),
        .ext_access(ext_access), .rd_strobe_n(rd_strobe_n),
        .wr_strobe_n(wr_strobe_n), .bus_ack(bus_ack)
    );

    // vector: dir, latch, pin_in, expected data read, expected oe
    localparam int NVEC = 4;
    localparam logic [39:0] VEC [NVEC] = '{
        {8'h00, 8'hAA, 8'h55, 8'h56, 8'h03},
        {8'hFF, 8'h3C, 8'hC3, 8'h3C, 8'hFF},
        {8'hF0, 8'h0F, 8'hF0, 8'h03, 8'hF3},
        {8'h0C, 8'hA5, 8'h5A, 8'h55, 8'h0F}
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic write_reg(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; reg_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic read_reg(input logic [1:0] a, output logic [7:0] d);
        reg_addr = a;
        #0.5;
        d = rd_data;
    endtask

    task automatic do_reset(input logic s);
        @(negedge clk);
        rst = 1'b1; strap_pu = s;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0; strap_pu = ~s;
    endtask

    logic [7:0] rv;

    initial begin
        // R1, R2: reset with strap high
        do_reset(1'b1);
        check("R1 oe", pin_oe, 8'h03);
        check("R1 out", {6'b0, pin_out[1:0]}, 8'h03);
        read_reg(2'd1, rv); check("R1 dir", rv, 8'h00);
        read_reg(2'd2, rv); check("R1 func", rv, 8'h00);
        check("R10 pull strap1", pull_en, 8'hFC);
        write_reg(2'd1, 8'hFC);
        read_reg(2'd0, rv); check("R2 latch strap1", rv, 8'hFF);
        check("R9 out strap1", pin_out, 8'hFF);
        check("R10 outputs no pull", pull_en, 8'h00);

        // R2, R10: reset with strap low
        do_reset(1'b0);
        check("R10 pull strap0", pull_en, 8'h80);
        write_reg(2'd1, 8'hFC);
        read_reg(2'd0, rv); check("R2 latch strap0", rv, 8'h83);

        // R4: unimplemented bits
        write_reg(2'd1, 8'hFF);
        read_reg(2'd1, rv); check("R4 dir mask", rv, 8'hFC);
        write_reg(2'd2, 8'hFF);
        read_reg(2'd2, rv); check("R4 func mask", rv, 8'h77);
        write_reg(2'd2, 8'h00);
        write_reg(2'd1, 8'h03);
        read_reg(2'd1, rv); check("R4 dir low ignored", rv, 8'h00);
        check("R3 oe fixed", pin_oe, 8'h03);

        // R5: address 3 writes nothing, reads 0
        write_reg(2'd0, 8'h5A);
        write_reg(2'd3, 8'hFF);
        read_reg(2'd3, rv); check("R6 addr3 read", rv, 8'h00);
        read_reg(2'd1, rv); check("R5 addr3 dir", rv, 8'h00);
        read_reg(2'd2, rv); check("R5 addr3 func", rv, 8'h00);
        check("R5 addr3 latch", pin_out, 8'h5A);

        // R3, R6, R9: vector table
        for (int k = 0; k < NVEC; k++) begin
            write_reg(2'd1, VEC[k][39:32]);
            write_reg(2'd0, VEC[k][31:24]);
            pin_in = VEC[k][23:16];
            read_reg(2'd0, rv); check("R6 data read", rv, VEC[k][15:8]);
            check("R3 oe", pin_oe, VEC[k][7:0]);
            check("R9 out", pin_out, VEC[k][31:24]);
        end

        // R5: write visible only after the edge
        @(negedge clk);
        wr_en = 1'b1; reg_addr = 2'd0; wr_data = 8'h00;
        #1; check("R5 before edge", pin_out, 8'hA5);
        @(negedge clk);
        wr_en = 1'b0;
        check("R5 after edge", pin_out, 8'h00);

        // R7: read strobe
        write_reg(2'd0, 8'h00);
        check("R9 func clear latch", {7'b0, pin_out[0]}, 8'h00);
        write_reg(2'd2, 8'h01);
        ext_access = 1'b0; rd_strobe_n = 1'b0; #0.5;
        check("R7 idle high", {7'b0, pin_out[0]}, 8'h01);
        ext_access = 1'b1; #0.5;
        check("R7 strobe low", {7'b0, pin_out[0]}, 8'h00);
        rd_strobe_n = 1'b1; #0.5;
        check("R7 strobe high", {7'b0, pin_out[0]}, 8'h01);
        check("R7 bit1 unaffected", {7'b0, pin_out[1]}, 8'h00);

        // R8: write strobe
        write_reg(2'd2, 8'h02);
        ext_access = 1'b1; wr_strobe_n = 1'b0; #0.5;
        check("R8 strobe low", {7'b0, pin_out[1]}, 8'h00);
        ext_access = 1'b0; #0.5;
        check("R8 idle high", {7'b0, pin_out[1]}, 8'h01);
        check("R8 bit0 latch", {7'b0, pin_out[0]}, 8'h00);

        // concurrent: function write while a read strobe is active
        write_reg(2'd2, 8'h00);
        write_reg(2'd0, 8'h01);
        ext_access = 1'b1; rd_strobe_n = 1'b0;
        @(negedge clk);
        wr_en = 1'b1; reg_addr = 2'd2; wr_data = 8'h01;
        #1; check("R7 before func edge", {7'b0, pin_out[0]}, 8'h01);
        @(negedge clk);
        wr_en = 1'b0;
        check("R7 after func edge", {7'b0, pin_out[0]}, 8'h00);
        ext_access = 1'b0; rd_strobe_n = 1'b1; wr_strobe_n = 1'b1;

        // R11: acknowledge pull-ups, strap low
        do_reset(1'b0);
        bus_ack = 1'b1;
        write_reg(2'd2, 8'h44);
        check("R11 ack high", pull_en, 8'h80);
        bus_ack = 1'b0; #0.5;
        check("R11 ack low", pull_en, 8'hC4);
        write_reg(2'd2, 8'h00);
        check("R11 func clear", pull_en, 8'h80);
        @(negedge clk);
        wr_en = 1'b1; reg_addr = 2'd2; wr_data = 8'h04;
        #1; check("R11 before edge", pull_en, 8'h80);
        @(negedge clk);
        wr_en = 1'b0;
        check("R11 after edge", pull_en, 8'h84);
        bus_ack = 1'b1;

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                total++; bad++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule